// File: doc/BRIEF.md
# Bus Trace Capture Controller

This block steers a 1024-word, 16-bit trace memory while a bus is being watched. On every clock where the controller is armed and the store qualifier is high, it presents the current bus word to the memory's write port at the current write address. The address then advances by one. The memory sits outside the block. The controller drives its write enable, address and data directly, so the write lands in the same cycle as the qualifier.

Two configuration inputs shape a run. The clear option, sampled on the start pulse, resets the write address to 000h. Without it, the run resumes where the previous one left off. The wrap option, sampled on the write at address 3FFh, chooses what that write does:
- With wrap selected, the address rolls to 000h, recording continues and older samples are overwritten. A sticky wrapped flag marks that this has happened, so readout logic can tell the oldest sample sits at the current address.
- Without wrap, that write is the last one. The controller enters a full state and refuses writes until the next start.

The control core is a three-state machine:
- IDLE: not recording.
- RUN: recording qualified samples.
- FULL: the end of memory was reached without wrap.

Its transitions are:
- ARM: IDLE to RUN on start.
- REARM: RUN to RUN on start.
- HALT: RUN to IDLE on stop.
- FILL: RUN to FULL on the last write without wrap.
- RESTART: FULL to RUN on start.

Top module: `trace_capture_ctrl`

## Requirements
- R1: After reset, running, full and wrapped are 0, the address is 000h and the write enable is 0.
- R2: The write enable is high exactly in cycles where running is 1 and the store qualifier is 1. In such a cycle the write data equals the bus input and the write address equals the current address.
- R3: A write advances the address by one on the next cycle. A cycle without a write leaves the address unchanged, unless a clearing start is applied.
- R4: A start pulse makes running 1 on the next cycle (ARM, REARM, RESTART). If the clear option is 1 in that cycle, the address becomes 000h and wrapped becomes 0.
- R5: A start with the clear option at 0 keeps the address and the wrapped flag, so the run resumes from where the previous one ended.
- R6: Stop without start drops running on the next cycle (HALT). A qualified write in the stop cycle still happens. Start wins over stop in the same cycle.
- R7: With wrap at 0, a write at 3FFh is followed by full=1, running=0 and address 000h (FILL). Qualified cycles then produce no writes, and stop leaves full set.
- R8: With wrap at 1, a write at 3FFh is followed by address 000h, running=1 and wrapped=1. Later writes overwrite from 000h upward.
- R9: A start in FULL clears full and sets running on the next cycle (RESTART).
- R10: The clear option acts only in a start cycle, and the wrap option acts only in a write cycle at 3FFh. At other times neither option changes the address or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_data | input | 16 | Monitored bus word |
| store_en | input | 1 | Per-cycle store qualifier |
| start | input | 1 | Begin (or re-begin) a test run |
| stop | input | 1 | End the current run |
| cfg_clear | input | 1 | Clear the address to 000h on start |
| cfg_wrap | input | 1 | 1: wrap and overwrite at 3FFh, 0: stop there |
| mem_we | output | 1 | Trace memory write enable |
| mem_addr | output | 10 | Trace memory write address |
| mem_wdata | output | 16 | Trace memory write data |
| cur_addr | output | 10 | Current write address |
| full | output | 1 | Run ended at last address without wrap |
| running | output | 1 | Controller is recording |
| wrapped | output | 1 | Address has rolled over since the last clearing start |

## Verification
The hardest situations to reach are the two end-of-memory outcomes, because they need exactly 1023 qualified writes before the decisive one. The stimulus drives long runs of back-to-back qualified cycles from a cleared address. For the wrap case it holds the wrap option low until the very cycle of the write at 3FFh, which also shows the option is sampled only there. A resume-without-clear run after a halt, and a start from the full state, cover the address carrying across runs.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;

    typedef enum logic [1:0] {
        TC_IDLE = 2'd0,
        TC_RUN  = 2'd1,
        TC_FULL = 2'd2
    } tc_state_e;

endpackage

// File: rtl/trace_cap_fsm.sv
module trace_cap_fsm
    import trace_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic last_write,
    output logic running,
    output logic full
);

    tc_state_e state_q;
    tc_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ARM, REARM, FILL, HALT, RESTART
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TC_IDLE: begin
                if (start) state_d = TC_RUN;
            end
            TC_RUN: begin
                if (start)           state_d = TC_RUN;
                else if (last_write) state_d = TC_FULL;
                else if (stop)       state_d = TC_IDLE;
            end
            TC_FULL: begin
                if (start) state_d = TC_RUN;
            end
            default: state_d = TC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running = 1'b0;
        full    = 1'b0;
        unique case (state_q)
            TC_IDLE: ;
            TC_RUN:  running = 1'b1;
            TC_FULL: full    = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/trace_cap_addr.sv
module trace_cap_addr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              step,
    input  logic              wrap_en,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last,
    output logic              wrapped
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    assign at_last = (addr == LAST_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr    <= '0;
            wrapped <= 1'b0;
        end else if (clr) begin
            addr    <= '0;
            wrapped <= 1'b0;
        end else if (step) begin
            addr <= addr + 1'b1;
            if (at_last && wrap_en) begin
                wrapped <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/trace_cap_wport.sv
module trace_cap_wport #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              running,
    input  logic              store_en,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata
);

    assign we    = running & store_en;
    assign waddr = addr;
    assign wdata = bus_data;

endmodule

// File: rtl/trace_capture_ctrl.sv
module trace_capture_ctrl #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              store_en,
    input  logic              start,
    input  logic              stop,
    input  logic              cfg_clear,
    input  logic              cfg_wrap,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              full,
    output logic              running,
    output logic              wrapped
);

    logic at_last;
    logic last_write;
    logic addr_clr;

    assign addr_clr   = start & cfg_clear;
    assign last_write = mem_we & at_last & ~cfg_wrap;

    trace_cap_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .last_write (last_write),
        .running    (running),
        .full       (full)
    );

    trace_cap_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (addr_clr),
        .step    (mem_we),
        .wrap_en (cfg_wrap),
        .addr    (cur_addr),
        .at_last (at_last),
        .wrapped (wrapped)
    );

    trace_cap_wport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wport (
        .running  (running),
        .store_en (store_en),
        .bus_data (bus_data),
        .addr     (cur_addr),
        .we       (mem_we),
        .waddr    (mem_addr),
        .wdata    (mem_wdata)
    );

endmodule

// File: rtl/trace_capture_ctrl_chk.sv
module trace_capture_ctrl_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              stop,
    input logic              cfg_clear,
    input logic              cfg_wrap,
    input logic              mem_we,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              full,
    input logic              running,
    input logic              wrapped
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !start && cur_addr != LAST_ADDR) |=>
        (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we && !start) |=> $stable(cur_addr));

    // R4
    clear_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_clear) |=> (running && cur_addr == '0 && !wrapped));

    // R6
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && stop && !start) |=> !running);

    // R7
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cur_addr == LAST_ADDR && !cfg_wrap && !start) |=>
        (full && !running && cur_addr == '0));

    // R7
    full_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !mem_we);

    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cur_addr == LAST_ADDR && cfg_wrap && !start) |=>
        (running && wrapped && cur_addr == '0));

    // R9
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && running));

endmodule

bind trace_capture_ctrl trace_capture_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .cfg_clear (cfg_clear),
    .cfg_wrap  (cfg_wrap),
    .mem_we    (mem_we),
    .cur_addr  (cur_addr),
    .full      (full),
    .running   (running),
    .wrapped   (wrapped)
);

// File: tb/trace_capture_ctrl_test.sv
`timescale 1ns/1ps
module trace_capture_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_data = '0;
    logic        store_en = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        cfg_clear = 1'b0;
    logic        cfg_wrap = 1'b0;
    logic        mem_we;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [9:0]  cur_addr;
    logic        full;
    logic        running;
    logic        wrapped;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    trace_capture_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_data  (bus_data),
        .store_en  (store_en),
        .start     (start),
        .stop      (stop),
        .cfg_clear (cfg_clear),
        .cfg_wrap  (cfg_wrap),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .cur_addr  (cur_addr),
        .full      (full),
        .running   (running),
        .wrapped   (wrapped)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // advance one clock: inputs change just after the falling edge, outputs settle
    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1", "running", running, 0);
        chk("R1", "full", full, 0);
        chk("R1", "wrapped", wrapped, 0);
        chk("R1", "addr", cur_addr, 0);
        chk("R1", "we", mem_we, 0);
    endtask

    task automatic t_clear_start_and_write();
        store_en = 1'b1; start = 1'b1; cfg_clear = 1'b1; #1;
        chk("R2", "we while idle", mem_we, 0);
        cyc();
        start = 1'b0; cfg_clear = 1'b0; store_en = 1'b0; #1;
        chk("R4", "running after start", running, 1);
        chk("R4", "addr after clear", cur_addr, 0);
        chk("R2", "we without qualifier", mem_we, 0);
        for (int i = 0; i < 3; i++) begin
            store_en = 1'b1; bus_data = 16'h1234 + 16'(i * 16'h0101); #1;
            chk("R2", "we", mem_we, 1);
            chk("R2", "wdata", mem_wdata, 16'h1234 + i * 16'h0101);
            chk("R2", "waddr", mem_addr, i);
            cyc();
        end
        store_en = 1'b0; cfg_clear = 1'b1; cyc();
        chk("R3", "addr after 3 writes and idle cycle", cur_addr, 3);
        chk("R10", "clear option without start", cur_addr, 3);
        cfg_clear = 1'b0;
    endtask

    task automatic t_halt();
        store_en = 1'b1; stop = 1'b1; bus_data = 16'hBEEF; #1;
        chk("R6", "write in stop cycle", mem_we, 1);
        chk("R6", "addr in stop cycle", mem_addr, 3);
        cyc();
        stop = 1'b0; #1;
        chk("R6", "running after stop", running, 0);
        chk("R3", "addr after stop write", cur_addr, 4);
        chk("R2", "we while idle", mem_we, 0);
        cyc();
        chk("R3", "addr held while idle", cur_addr, 4);
        store_en = 1'b0;
    endtask

    task automatic t_resume();
        start = 1'b1; cfg_clear = 1'b0; cyc();
        start = 1'b0; #1;
        chk("R5", "running after resume", running, 1);
        chk("R5", "addr kept", cur_addr, 4);
        start = 1'b1; stop = 1'b1; cyc();
        start = 1'b0; stop = 1'b0; #1;
        chk("R6", "start beats stop", running, 1);
        stop = 1'b1; cyc();
        stop = 1'b0; #1;
        chk("R6", "halted", running, 0);
    endtask

    task automatic t_fill_nowrap();
        cfg_wrap = 1'b0; start = 1'b1; cfg_clear = 1'b1; cyc();
        start = 1'b0; cfg_clear = 1'b0; store_en = 1'b1;
        for (int i = 0; i < 1023; i++) begin
            bus_data = 16'(i);
            cyc();
        end
        bus_data = 16'h0F0F; #1;
        chk("R7", "addr before last write", mem_addr, 1023);
        chk("R7", "last write enabled", mem_we, 1);
        cyc();
        chk("R7", "full", full, 1);
        chk("R7", "running", running, 0);
        chk("R7", "addr after last", cur_addr, 0);
        for (int i = 0; i < 4; i++) begin
            chk("R7", "no write when full", mem_we, 0);
            cyc();
        end
        chk("R7", "addr held when full", cur_addr, 0);
        stop = 1'b1; cyc();
        stop = 1'b0; #1;
        chk("R7", "stop leaves full", full, 1);
        store_en = 1'b0;
    endtask

    task automatic t_restart();
        start = 1'b1; cfg_clear = 1'b0; cyc();
        start = 1'b0; #1;
        chk("R9", "full cleared", full, 0);
        chk("R9", "running", running, 1);
        chk("R9", "addr", cur_addr, 0);
        stop = 1'b1; cyc();
        stop = 1'b0; #1;
    endtask

    task automatic t_wrap();
        cfg_wrap = 1'b0; start = 1'b1; cfg_clear = 1'b1; cyc();
        start = 1'b0; cfg_clear = 1'b0; store_en = 1'b1;
        for (int i = 0; i < 1023; i++) begin
            bus_data = 16'(i);
            cyc();
        end
        cfg_wrap = 1'b1; #1;
        chk("R8", "addr at last", mem_addr, 1023);
        cyc();
        cfg_wrap = 1'b0; #1;
        chk("R8", "running after rollover", running, 1);
        chk("R8", "wrapped", wrapped, 1);
        chk("R8", "full stays 0", full, 0);
        chk("R8", "addr rolled", cur_addr, 0);
        bus_data = 16'hCAFE; #1;
        chk("R8", "overwrite addr", mem_addr, 0);
        chk("R8", "overwrite data", mem_wdata, 16'hCAFE);
        cyc(); cyc();
        chk("R8", "addr after overwrites", cur_addr, 2);
        store_en = 1'b0; start = 1'b1; cfg_clear = 1'b0; cyc();
        start = 1'b0; #1;
        chk("R5", "wrapped kept", wrapped, 1);
        chk("R5", "addr kept", cur_addr, 2);
        start = 1'b1; cfg_clear = 1'b1; cyc();
        start = 1'b0; cfg_clear = 1'b0; #1;
        chk("R4", "wrapped cleared", wrapped, 0);
        chk("R4", "addr cleared", cur_addr, 0);
    endtask

    initial begin
        #4_000_000;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        cyc(); cyc();
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_clear_start_and_write();
        t_halt();
        t_resume();
        t_fill_nowrap();
        t_restart();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule